// File: doc/BRIEF.md
# I2C Target Register Port

This block is an I2C target that lets an external bus controller write and read a small internal register file. SCL and SDA come in raw from the pads. Each line passes through a two-flop synchroniser and a glitch filter. After that, the block finds START and STOP conditions and checks the 7-bit device address and the direction bit. It acknowledges bytes by driving an open-drain enable that pulls SDA low.

Registers are 32 bits wide and move as four bytes, most significant byte first. The first byte of every write transfer is always a subaddress, which selects a word. Later bytes are gathered into groups of four. Each complete group is committed to the addressed word, and the next group goes to the following word. A read has no subaddress phase. It starts at the subaddress left by the latest write and steps through the same words. A controller therefore sets the pointer with a write that carries only a subaddress, then issues the read, either after a STOP or after a repeated START.

Top module: `i2c_regport`

## Requirements
- R1: After reset the SDA pull-down is off. A falling SDA while SCL is high (START) makes the block ready for an address byte. A rising SDA while SCL is high (STOP) returns it to idle with SDA released.
- R2: The first byte after START is taken MSB first as a 7-bit address and a direction bit (1 = read). When the address equals DEV_ADDR, SDA is held low through the ninth clock. Otherwise nothing is acknowledged until the next START. The block changes its SDA drive only while SCL is low.
- R3: In a write, the first byte after the address is stored as the subaddress and is acknowledged. It is never written into a register.
- R4: Write data bytes are packed MSB first into 32-bit words. Word k of the transfer goes to register (subaddress + k) mod NUM_WORDS, and only when all four of its bytes have arrived.
- R5: A group of fewer than four bytes that is cut off by STOP is dropped, and the target register keeps its old value.
- R6: At most MAX_BYTES (20) data bytes are accepted in one write. The next byte is not acknowledged, is discarded, and neither it nor any later byte of that transfer is acknowledged.
- R7: A read returns bytes MSB first, starting at byte 31:24 of the register named by the most recently stored subaddress. It moves to the next register after every four bytes. A write that carries only a subaddress sets this start point, and this works after a STOP as well as across a repeated START.
- R8: When a write carrying only a subaddress is followed by another write, the first byte of the second write replaces the subaddress and is not treated as data.
- R9: In a read, SDA is released for the controller's acknowledge bit. After a NACK the block stops driving SDA and stays silent until STOP or START.
- R10: Transfers work with SCL periods of 20 and 80 system clocks.
- R11: A pulse on SDA shorter than FILT_LEN system clocks is ignored. It causes no START, no STOP and no corrupted bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL level from the pad |
| sda_in | input | 1 | Raw SDA level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |

## Verification
A table of subaddress and word pairs is written and read back. The pairs use words at both ends of the array and a subaddress above NUM_WORDS, to show that address wrapping and byte order are kept. Directed transfers then cover the following cases:
- A subaddress-only write followed by a second write, which separates the "first byte is subaddress" rule from plain data.
- A write cut off after six data bytes, which shows that a partial group is dropped.
- A 24-byte write, which locates the acknowledge cut-off exactly at the 21st data byte.
- A read ended by NACK and then clocked on, which shows that the block stays silent.
- A wrong device address.
- A repeated-START read.
- A slow SCL rate.
- A sub-filter SDA pulse during SCL high.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_RX,
        S_RX_ACK,
        S_TX,
        S_TX_ACK,
        S_WAIT
    } rp_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    // Byte lane 0 is the most significant byte of a word.
    function automatic logic [7:0] lane_byte(input logic [31:0] w, input logic [1:0] lane);
        return w[8*(3-lane) +: 8];
    endfunction

endpackage

// File: rtl/i2c_rp_filter.sv
module i2c_rp_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic filt
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            filt   <= 1'b1;
            cnt    <= '0;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (sync_q[1] == filt) begin
                cnt <= '0;
            end else if (cnt == CW'(FILT_LEN - 1)) begin
                filt <= sync_q[1];
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R11: the filtered level only moves to a value the synchroniser held
    a_r11_filter_settled: assert property (@(posedge clk) disable iff (rst)
        (filt != $past(filt)) |-> ($past(sync_q[1]) == filt));

endmodule

// File: rtl/i2c_rp_regfile.sv
module i2c_rp_regfile #(
    parameter int NUM_WORDS = 8,
    localparam int AW = $clog2(NUM_WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);
    logic [31:0] mem [NUM_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
    import i2c_regport_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h2C,
    parameter int         NUM_WORDS = 8,
    parameter int         MAX_BYTES = 20,
    parameter int         FILT_LEN  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe
);
    localparam int AW = $clog2(NUM_WORDS);
    localparam int CW = $clog2(MAX_BYTES + 1);

    // ---- input conditioning: index 1 = SCL, index 0 = SDA
    logic [1:0] raw_lines, filt_lines;
    assign raw_lines = {scl_in, sda_in};

    for (genvar i = 0; i < 2; i++) begin : g_filt
        i2c_rp_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk (clk),
            .rst (rst),
            .raw (raw_lines[i]),
            .filt(filt_lines[i])
        );
    end

    logic scl_f, sda_f, scl_q, sda_q;
    assign scl_f = filt_lines[1];
    assign sda_f = filt_lines[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    bus_evt_t ev;
    always_comb begin
        ev.scl_rise = scl_f & ~scl_q;
        ev.scl_fall = ~scl_f & scl_q;
        ev.start    = scl_f & scl_q & sda_q & ~sda_f;
        ev.stop     = scl_f & scl_q & ~sda_q & sda_f;
    end

    // ---- transfer state
    rp_state_e     state;
    logic [3:0]    bitcnt;
    logic [7:0]    shreg, txsh, subaddr;
    logic          rw, first, acked;
    logic [1:0]    lane;
    logic [CW-1:0] dcnt;
    logic [23:0]   held;
    logic [AW-1:0] wptr, rptr, wr_addr;
    logic          wr_en;
    logic [31:0]   wr_data, rdata;
    logic [7:0]    cur_byte;

    assign cur_byte = lane_byte(rdata, lane);

    i2c_rp_regfile #(.NUM_WORDS(NUM_WORDS)) u_regs (
        .clk  (clk),
        .rst  (rst),
        .we   (wr_en),
        .waddr(wr_addr),
        .wdata(wr_data),
        .raddr(rptr),
        .rdata(rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            txsh    <= '0;
            subaddr <= '0;
            rw      <= 1'b0;
            first   <= 1'b0;
            acked   <= 1'b0;
            lane    <= '0;
            dcnt    <= '0;
            held    <= '0;
            wptr    <= '0;
            rptr    <= '0;
            wr_addr <= '0;
            wr_en   <= 1'b0;
            wr_data <= '0;
            sda_oe  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (ev.start) begin
                state  <= S_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
                rptr   <= subaddr[AW-1:0];
                lane   <= '0;
            end else if (ev.stop) begin
                state  <= S_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    S_ADDR: begin
                        if (ev.scl_rise) begin
                            shreg  <= {shreg[6:0], sda_f};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.scl_fall && bitcnt == 4'd8) begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                rw     <= shreg[0];
                                sda_oe <= 1'b1;
                                state  <= S_ADDR_ACK;
                            end else begin
                                state <= S_WAIT;
                            end
                        end
                    end
                    S_ADDR_ACK: begin
                        if (ev.scl_fall) begin
                            bitcnt <= '0;
                            if (rw) begin
                                state  <= S_TX;
                                sda_oe <= ~cur_byte[7];
                                txsh   <= {cur_byte[6:0], 1'b0};
                            end else begin
                                state  <= S_RX;
                                sda_oe <= 1'b0;
                                first  <= 1'b1;
                                lane   <= '0;
                                dcnt   <= '0;
                            end
                        end
                    end
                    S_RX: begin
                        if (ev.scl_rise) begin
                            shreg  <= {shreg[6:0], sda_f};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            if (first) begin
                                subaddr <= shreg;
                                wptr    <= shreg[AW-1:0];
                                first   <= 1'b0;
                                sda_oe  <= 1'b1;
                                state   <= S_RX_ACK;
                            end else if (dcnt < CW'(MAX_BYTES)) begin
                                dcnt   <= dcnt + 1'b1;
                                sda_oe <= 1'b1;
                                state  <= S_RX_ACK;
                                if (lane == 2'd3) begin
                                    wr_en   <= 1'b1;
                                    wr_addr <= wptr;
                                    wr_data <= {held, shreg};
                                    wptr    <= wptr + 1'b1;
                                    lane    <= '0;
                                end else begin
                                    held <= {held[15:0], shreg};
                                    lane <= lane + 1'b1;
                                end
                            end else begin
                                state <= S_WAIT;
                            end
                        end
                    end
                    S_RX_ACK: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= S_RX;
                        end
                    end
                    S_TX: begin
                        if (ev.scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                acked  <= 1'b0;
                                state  <= S_TX_ACK;
                            end else begin
                                sda_oe <= ~txsh[7];
                                txsh   <= {txsh[6:0], 1'b0};
                            end
                        end
                    end
                    S_TX_ACK: begin
                        if (ev.scl_rise) begin
                            acked <= ~sda_f;
                            if (!sda_f) begin
                                lane <= lane + 1'b1;
                                if (lane == 2'd3) rptr <= rptr + 1'b1;
                            end
                        end else if (ev.scl_fall) begin
                            if (acked) begin
                                bitcnt <= '0;
                                state  <= S_TX;
                                sda_oe <= ~cur_byte[7];
                                txsh   <= {cur_byte[6:0], 1'b0};
                            end else begin
                                state <= S_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: a START always leads to address reception
    a_r1_start_to_addr: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (state == S_ADDR));
    // R1: a STOP returns to idle with SDA released
    a_r1_stop_releases: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (state == S_IDLE && !sda_oe));
    // R2: the pull-down is only switched on while SCL is low
    a_r2_drive_on_low_scl: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_f);
    // R9: silent while waiting for the next START or STOP
    a_r9_silent_wait: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT) |-> !sda_oe);
    // R6: no commit once the data byte limit has been passed
    a_r6_limit_kept: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (dcnt <= CW'(MAX_BYTES)));
    // R4: a word commit needs four more bytes before the next one
    a_r4_commit_spacing: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

endmodule

// File: tb/tb_i2c_regport.sv
module tb_i2c_regport;
    localparam int CLK_P = 10;
    localparam logic [6:0] ADDR = 7'h2C;
    localparam logic [39:0] VEC [4] = '{
        40'h01_11223344,
        40'h07_A5C35A3C,
        40'h00_00FF00FF,
        40'h0A_DEADBEEF
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    logic sda_bus;
    logic glitch = 1'b0;
    int   q = 5;
    int   n_chk = 0;
    int   n_fail = 0;

    logic [7:0]  wbuf [32];
    logic        wack [34];
    logic [7:0]  rbuf [32];
    logic        rack;
    logic [31:0] exp_mem [8];

    assign sda_bus = ~(m_low | sda_oe);

    always #(CLK_P/2) clk = ~clk;

    i2c_regport dut (
        .clk   (clk),
        .rst   (rst),
        .scl_in(m_scl),
        .sda_in(sda_bus),
        .sda_oe(sda_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic half();
        repeat (q) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        half(); m_low = ~b;
        half(); m_scl = 1'b1;
        half();
        if (glitch && b) begin
            m_low = 1'b1; @(negedge clk); m_low = 1'b0;
        end
        half(); m_scl = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        half(); m_low = 1'b0;
        half(); m_scl = 1'b1;
        half(); b = sda_bus;
        half(); m_scl = 1'b0;
    endtask

    task automatic bus_start();
        half(); m_low = 1'b0;
        half(); m_scl = 1'b1;
        half(); m_low = 1'b1;
        half(); m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        half(); m_low = 1'b1;
        half(); m_scl = 1'b1;
        half(); m_low = 1'b0;
        half();
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        get_bit(a);
        ack = ~a;
    endtask

    task automatic rbyte(output logic [7:0] b, input logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            get_bit(x);
            b[i] = x;
        end
        send_bit(~ack);
    endtask

    // wack[0]=address, wack[1]=subaddress, wack[2+i]=data byte i
    task automatic do_write(input logic [7:0] sub, input int n, input bit with_stop);
        bus_start();
        wbyte({ADDR, 1'b0}, wack[0]);
        wbyte(sub, wack[1]);
        for (int i = 0; i < n; i++) wbyte(wbuf[i], wack[2+i]);
        if (with_stop) bus_stop();
    endtask

    task automatic do_read(input int n);
        bus_start();
        wbyte({ADDR, 1'b1}, rack);
        for (int i = 0; i < n; i++) rbyte(rbuf[i], i != n-1);
        bus_stop();
    endtask

    task automatic put_word(input int idx, input logic [31:0] w);
        for (int k = 0; k < 4; k++) wbuf[idx*4+k] = w[8*(3-k) +: 8];
    endtask

    function automatic logic [31:0] got_word(input int idx);
        return {rbuf[idx*4], rbuf[idx*4+1], rbuf[idx*4+2], rbuf[idx*4+3]};
    endfunction

    initial begin
        repeat (190000) @(negedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) exp_mem[i] = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R1: reset state
        chk(sda_oe == 1'b0, "R1 reset drive", {31'd0, sda_oe}, 32'd0);
        chk(sda_bus == 1'b1, "R1 bus idle high", {31'd0, sda_bus}, 32'd1);

        // Vector table: write word at subaddress, then read it back
        for (int v = 0; v < 4; v++) begin
            logic [7:0]  sub;
            logic [31:0] w;
            sub = VEC[v][39:32];
            w   = VEC[v][31:0];
            put_word(0, w);
            do_write(sub, 4, 1'b1);
            exp_mem[sub[2:0]] = w;
            chk(wack[0], "R2 address ack", {31'd0, wack[0]}, 32'd1);
            chk(wack[1], "R3 subaddress ack", {31'd0, wack[1]}, 32'd1);
            chk(wack[5], "R4 last data ack", {31'd0, wack[5]}, 32'd1);
            do_read(4);
            chk(got_word(0) == w, "R7 read back", got_word(0), w);
        end

        // R2: wrong device address gets no acknowledge at all
        bus_start();
        wbyte({7'h11, 1'b0}, wack[0]);
        wbyte(8'h00, wack[1]);
        bus_stop();
        chk(!wack[0], "R2 wrong address nack", {31'd0, wack[0]}, 32'd0);
        chk(!wack[1], "R2 silent after mismatch", {31'd0, wack[1]}, 32'd0);

        // R8: subaddress-only write then a second write
        do_write(8'h03, 0, 1'b1);
        put_word(0, 32'h0BADF00D);
        wbuf[0] = 8'h05;
        for (int k = 0; k < 4; k++) wbuf[1+k] = 8'h60 + 8'(k);
        do_write(8'h02, 0, 1'b1);
        bus_start();
        wbyte({ADDR, 1'b0}, wack[0]);
        for (int k = 0; k < 5; k++) wbyte(wbuf[k], wack[1+k]);
        bus_stop();
        exp_mem[5] = 32'h60616263;
        do_write(8'h05, 0, 1'b1);
        do_read(4);
        chk(got_word(0) == exp_mem[5], "R8 second write replaces subaddress", got_word(0), exp_mem[5]);
        do_write(8'h02, 0, 1'b1);
        do_read(4);
        chk(got_word(0) == exp_mem[2], "R3 subaddress byte not stored as data", got_word(0), exp_mem[2]);

        // R5: partial group dropped at STOP
        put_word(0, 32'hC0C1C2C3);
        wbuf[4] = 8'hEE; wbuf[5] = 8'hEF;
        do_write(8'h03, 6, 1'b1);
        exp_mem[3] = 32'hC0C1C2C3;
        do_write(8'h03, 0, 1'b1);
        do_read(8);
        chk(got_word(0) == exp_mem[3], "R4 full group committed", got_word(0), exp_mem[3]);
        chk(got_word(1) == exp_mem[4], "R5 partial group dropped", got_word(1), exp_mem[4]);

        // R6: 24 data bytes, only 20 accepted
        for (int i = 0; i < 24; i++) wbuf[i] = 8'h10 + 8'(i);
        do_write(8'h06, 24, 1'b1);
        for (int k = 0; k < 5; k++)
            exp_mem[(6+k) % 8] = {wbuf[k*4], wbuf[k*4+1], wbuf[k*4+2], wbuf[k*4+3]};
        chk(wack[21], "R6 20th data byte ack", {31'd0, wack[21]}, 32'd1);
        chk(!wack[22], "R6 21st data byte nack", {31'd0, wack[22]}, 32'd0);
        chk(!wack[25], "R6 later bytes nack", {31'd0, wack[25]}, 32'd0);
        do_write(8'h06, 0, 1'b1);
        do_read(24);
        for (int k = 0; k < 6; k++)
            chk(got_word(k) == exp_mem[(6+k) % 8], "R7 R4 word sequence with wrap",
                got_word(k), exp_mem[(6+k) % 8]);

        // R9: NACK ends the slave's drive
        do_write(8'h00, 0, 1'b1);
        bus_start();
        wbyte({ADDR, 1'b1}, rack);
        rbyte(rbuf[0], 1'b0);
        rbyte(rbuf[1], 1'b1);
        bus_stop();
        chk(rbuf[0] == exp_mem[0][31:24], "R7 first byte before nack", {24'd0, rbuf[0]}, {24'd0, exp_mem[0][31:24]});
        chk(rbuf[1] == 8'hFF, "R9 released after nack", {24'd0, rbuf[1]}, 32'hFF);

        // R7: subaddress write then repeated START read
        do_write(8'h01, 0, 1'b0);
        bus_start();
        wbyte({ADDR, 1'b1}, rack);
        for (int i = 0; i < 4; i++) rbyte(rbuf[i], i != 3);
        bus_stop();
        chk(rack, "R7 repeated start address ack", {31'd0, rack}, 32'd1);
        chk(got_word(0) == exp_mem[1], "R7 repeated start read", got_word(0), exp_mem[1]);

        // R11: short SDA pulses while SCL is high on every '1' bit
        glitch = 1'b1;
        put_word(0, 32'hF0E1D2C3);
        do_write(8'h04, 4, 1'b1);
        glitch = 1'b0;
        exp_mem[4] = 32'hF0E1D2C3;
        chk(wack[5], "R11 transfer survives pulses", {31'd0, wack[5]}, 32'd1);
        do_write(8'h04, 0, 1'b1);
        do_read(4);
        chk(got_word(0) == exp_mem[4], "R11 data intact", got_word(0), exp_mem[4]);

        // R10: slow SCL (80 system clocks per period)
        q = 20;
        put_word(0, 32'h13579BDF);
        do_write(8'h02, 4, 1'b1);
        exp_mem[2] = 32'h13579BDF;
        do_read(4);
        chk(got_word(0) == exp_mem[2], "R10 slow rate round trip", got_word(0), exp_mem[2]);
        chk(sda_oe == 1'b0, "R1 idle after stop", {31'd0, sda_oe}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule